// File: doc/BRIEF.md
# Sign-Magnitude Accumulator Adder with Zero Clamp

This block computes the next value of one fixed-point accumulator held in sign-magnitude form. Each accepted request supplies the current accumulator (sign bit plus magnitude), a memory operand in the same form, two operand modifier bits and an operation select. The modifiers reshape the operand before it is used. One bit drops its sign and the other inverts it. With them a single add also covers subtract, add-absolute and subtract-absolute, and there is no separate opcode for each.

Besides the plain add, the block has a magnitude-preserving add. When the effective operation is a subtraction and the operand is larger, the result would cross zero; in this mode a positive zero is returned instead. A load operation passes the modified operand straight through, so the same sign modifiers apply to loads. The result, a zero flag, a sign flag and an overflow flag are registered one cycle after a valid request, together with a valid strobe.

Top module: `smag_addclamp`

## Requirements
- R1: The effective operand sign is formed by first clearing the sign when `abs_mod`=1, then inverting it when `neg_mod`=1; the operand magnitude is never changed by the modifiers.
- R2: With `op_sel` 2'b00 or 2'b11 (add) and equal accumulator and effective operand signs, the result magnitude is the sum of magnitudes and the result sign is the accumulator sign.
- R3: In add with unlike signs, the smaller magnitude is subtracted from the larger and the result takes the sign of the larger; equal magnitudes give zero carrying the accumulator sign.
- R4: A carry out of the MAG_W-bit magnitude sum sets `ovf_flag` and the low MAG_W bits are kept; unlike-sign operations never set `ovf_flag`.
- R5: With `op_sel`=2'b01 (magnitude add), unlike signs and an operand magnitude strictly greater than the accumulator magnitude, the result is magnitude 0 with sign 0 (positive) and no overflow.
- R6: In magnitude add, every other case gives the same result as add, so the result sign always equals the accumulator sign.
- R7: With `op_sel`=2'b10 (load), the result is the modified operand (effective sign, operand magnitude) and `ovf_flag` is 0; the accumulator inputs are ignored.
- R8: `zero_flag` is 1 exactly when the result magnitude is 0, and `sign_flag` equals the result sign (1 = negative).
- R9: A request with `in_valid`=1 produces its result and `out_valid`=1 on the next clock edge; a cycle without `in_valid` leaves `out_valid`=0 and all result outputs unchanged.
- R10: During reset (`rst_n`=0) `out_valid`, the result and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| acc_sign | input | 1 | Accumulator sign, 1 = negative |
| acc_mag | input | MAG_W | Accumulator magnitude |
| opd_sign | input | 1 | Memory operand sign |
| opd_mag | input | MAG_W | Memory operand magnitude |
| neg_mod | input | 1 | Invert effective operand sign |
| abs_mod | input | 1 | Clear operand sign before inversion |
| op_sel | input | 2 | 00/11 add, 01 magnitude add, 10 load |
| out_valid | output | 1 | Result strobe |
| res_sign | output | 1 | Result sign |
| res_mag | output | MAG_W | Result magnitude |
| zero_flag | output | 1 | Result magnitude is zero |
| sign_flag | output | 1 | Result is negative |
| ovf_flag | output | 1 | Magnitude carry out |

## Verification
The hardest situation to reach is the zero clamp. It occurs only when the operation is magnitude add, the modifiers and input signs combine into an effective subtraction, and the operand magnitude is strictly larger. The stimulus reaches it from both accumulator signs: once through the negate modifier on a like-signed operand, and once through a directly unlike-signed operand. It also sets the equal-magnitude case beside it, where no clamp may occur and the accumulator sign must survive. A carry out of the all-ones magnitude is placed in magnitude mode as well, so that the overflow and clamp paths are seen apart.

// File: rtl/smag_pkg.sv
package smag_pkg;
  typedef enum logic [1:0] {
    OP_ADD     = 2'b00,
    OP_MAGADD  = 2'b01,
    OP_LOAD    = 2'b10,
    OP_ADD_ALT = 2'b11
  } op_e;
endpackage

// File: rtl/smag_opmod.sv
module smag_opmod (
  input  logic raw_sign,
  input  logic neg_mod,
  input  logic abs_mod,
  output logic eff_sign
);
  function automatic logic apply_mods(input logic s, input logic n, input logic a);
    logic t;
    t = a ? 1'b0 : s;
    return n ? ~t : t;
  endfunction

  assign eff_sign = apply_mods(raw_sign, neg_mod, abs_mod);
endmodule

// File: rtl/smag_core.sv
module smag_core #(
  parameter int MAG_W = 16
) (
  input  logic             a_sign,
  input  logic [MAG_W-1:0] a_mag,
  input  logic             b_sign,
  input  logic [MAG_W-1:0] b_mag,
  input  logic             clamp_en,
  output logic             r_sign,
  output logic [MAG_W-1:0] r_mag,
  output logic             r_ovf,
  output logic             like_evt,
  output logic             cross_evt,
  output logic             clamp_evt
);
  localparam int SUM_W = MAG_W + 1;

  function automatic logic [SUM_W-1:0] mag_sum(input logic [MAG_W-1:0] x, input logic [MAG_W-1:0] y);
    return {1'b0, x} + {1'b0, y};
  endfunction

  function automatic logic [MAG_W-1:0] mag_absdiff(input logic [MAG_W-1:0] x, input logic [MAG_W-1:0] y);
    return (x >= y) ? (x - y) : (y - x);
  endfunction

  logic [SUM_W-1:0] sum_w;
  logic [MAG_W-1:0] diff_w;
  logic             a_ge_b;

  assign sum_w     = mag_sum(a_mag, b_mag);
  assign diff_w    = mag_absdiff(a_mag, b_mag);
  assign a_ge_b    = (a_mag >= b_mag);
  assign like_evt  = (a_sign == b_sign);
  assign cross_evt = !like_evt && !a_ge_b;
  assign clamp_evt = clamp_en && cross_evt;

  always_comb begin
    r_sign = a_sign;
    r_mag  = '0;
    r_ovf  = 1'b0;
    if (like_evt) begin
      r_mag = sum_w[MAG_W-1:0];
      r_ovf = sum_w[MAG_W];
    end else if (clamp_evt) begin
      r_sign = 1'b0;
      r_mag  = '0;
    end else begin
      r_mag = diff_w;
      if (cross_evt) r_sign = b_sign;
    end
  end
endmodule

// File: rtl/smag_addclamp.sv
module smag_addclamp #(
  parameter int MAG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             acc_sign,
  input  logic [MAG_W-1:0] acc_mag,
  input  logic             opd_sign,
  input  logic [MAG_W-1:0] opd_mag,
  input  logic             neg_mod,
  input  logic             abs_mod,
  input  logic [1:0]       op_sel,
  output logic             out_valid,
  output logic             res_sign,
  output logic [MAG_W-1:0] res_mag,
  output logic             zero_flag,
  output logic             sign_flag,
  output logic             ovf_flag
);
  import smag_pkg::*;

  op_e              op;
  logic             eff_sign;
  logic             core_sign;
  logic [MAG_W-1:0] core_mag;
  logic             core_ovf;
  logic             like_evt;
  logic             cross_evt;
  logic             clamp_evt;
  logic             is_load;
  logic             is_magadd;
  logic             nxt_sign;
  logic [MAG_W-1:0] nxt_mag;
  logic             nxt_ovf;

  assign op        = op_e'(op_sel);
  assign is_load   = (op == OP_LOAD);
  assign is_magadd = (op == OP_MAGADD);

  smag_opmod u_opmod (
    .raw_sign (opd_sign),
    .neg_mod  (neg_mod),
    .abs_mod  (abs_mod),
    .eff_sign (eff_sign)
  );

  smag_core #(.MAG_W(MAG_W)) u_core (
    .a_sign    (acc_sign),
    .a_mag     (acc_mag),
    .b_sign    (eff_sign),
    .b_mag     (opd_mag),
    .clamp_en  (is_magadd),
    .r_sign    (core_sign),
    .r_mag     (core_mag),
    .r_ovf     (core_ovf),
    .like_evt  (like_evt),
    .cross_evt (cross_evt),
    .clamp_evt (clamp_evt)
  );

  always_comb begin
    if (is_load) begin
      nxt_sign = eff_sign;
      nxt_mag  = opd_mag;
      nxt_ovf  = 1'b0;
    end else begin
      nxt_sign = core_sign;
      nxt_mag  = core_mag;
      nxt_ovf  = core_ovf;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      res_sign  <= 1'b0;
      res_mag   <= '0;
      zero_flag <= 1'b0;
      sign_flag <= 1'b0;
      ovf_flag  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        res_sign  <= nxt_sign;
        res_mag   <= nxt_mag;
        zero_flag <= (nxt_mag == '0);
        sign_flag <= nxt_sign;
        ovf_flag  <= nxt_ovf;
      end
    end
  end

  AST_VALID_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(res_mag) && $stable(res_sign) && $stable(ovf_flag)); // R9
  AST_CLAMP_POSITIVE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && clamp_evt && !is_load |=> res_mag == '0 && !res_sign && !ovf_flag); // R5
  AST_NO_OVF_UNLIKE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !is_load && !like_evt |=> !ovf_flag); // R4
  AST_MAGADD_SIGN_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && is_magadd |=> (res_sign == $past(acc_sign)) || (res_mag == '0)); // R6
  AST_CROSS_TAKES_OPERAND_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !is_magadd && !is_load && cross_evt |=> res_sign == $past(eff_sign)); // R3
  AST_LOAD_NO_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && is_load |=> !ovf_flag && res_mag == $past(opd_mag)); // R7
  AST_ZERO_FLAG_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (zero_flag == (res_mag == '0)) && (sign_flag == res_sign)); // R8
endmodule

// File: tb/tb_smag_addclamp.sv
`timescale 1ns/1ps
module tb_smag_addclamp;
  localparam int W = 16;
  localparam int NV = 17;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         acc_sign = 1'b0;
  logic [W-1:0] acc_mag = '0;
  logic         opd_sign = 1'b0;
  logic [W-1:0] opd_mag = '0;
  logic         neg_mod = 1'b0;
  logic         abs_mod = 1'b0;
  logic [1:0]   op_sel = 2'b00;
  logic         out_valid, res_sign, zero_flag, sign_flag, ovf_flag;
  logic [W-1:0] res_mag;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  smag_addclamp #(.MAG_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .acc_sign(acc_sign), .acc_mag(acc_mag),
    .opd_sign(opd_sign), .opd_mag(opd_mag),
    .neg_mod(neg_mod), .abs_mod(abs_mod), .op_sel(op_sel),
    .out_valid(out_valid), .res_sign(res_sign), .res_mag(res_mag),
    .zero_flag(zero_flag), .sign_flag(sign_flag), .ovf_flag(ovf_flag)
  );

  // {acc_s, acc_m, opd_s, opd_m, neg, abs, op, exp_s, exp_m, exp_ovf}
  localparam logic [55:0] VEC [NV] = '{
    {1'b0, 16'h0100, 1'b0, 16'h0023, 1'b0, 1'b0, 2'b00, 1'b0, 16'h0123, 1'b0}, // R2
    {1'b0, 16'h0100, 1'b0, 16'h0030, 1'b1, 1'b0, 2'b00, 1'b0, 16'h00D0, 1'b0}, // R1 R3
    {1'b0, 16'h0010, 1'b0, 16'h0050, 1'b1, 1'b0, 2'b00, 1'b1, 16'h0040, 1'b0}, // R3
    {1'b0, 16'h0010, 1'b1, 16'h0005, 1'b0, 1'b1, 2'b00, 1'b0, 16'h0015, 1'b0}, // R1
    {1'b1, 16'h0020, 1'b1, 16'h0008, 1'b1, 1'b1, 2'b00, 1'b1, 16'h0028, 1'b0}, // R1 R2
    {1'b1, 16'h0040, 1'b0, 16'h0040, 1'b0, 1'b0, 2'b00, 1'b1, 16'h0000, 1'b0}, // R3
    {1'b0, 16'hFFF0, 1'b0, 16'h0020, 1'b0, 1'b0, 2'b00, 1'b0, 16'h0010, 1'b1}, // R4
    {1'b1, 16'h8000, 1'b1, 16'h8000, 1'b0, 1'b0, 2'b00, 1'b1, 16'h0000, 1'b1}, // R4
    {1'b0, 16'h0010, 1'b0, 16'h0030, 1'b1, 1'b0, 2'b01, 1'b0, 16'h0000, 1'b0}, // R5
    {1'b1, 16'h0050, 1'b1, 16'h0020, 1'b1, 1'b0, 2'b01, 1'b1, 16'h0030, 1'b0}, // R6
    {1'b0, 16'h0100, 1'b0, 16'h0001, 1'b0, 1'b0, 2'b01, 1'b0, 16'h0101, 1'b0}, // R6
    {1'b1, 16'h0007, 1'b0, 16'h0007, 1'b0, 1'b0, 2'b01, 1'b1, 16'h0000, 1'b0}, // R6
    {1'b1, 16'h0003, 1'b0, 16'h0009, 1'b0, 1'b0, 2'b01, 1'b0, 16'h0000, 1'b0}, // R5
    {1'b1, 16'h1234, 1'b1, 16'h0042, 1'b1, 1'b1, 2'b10, 1'b1, 16'h0042, 1'b0}, // R7
    {1'b0, 16'hFFFF, 1'b0, 16'h0099, 1'b1, 1'b0, 2'b10, 1'b1, 16'h0099, 1'b0}, // R7
    {1'b0, 16'h0005, 1'b0, 16'h0006, 1'b0, 1'b0, 2'b11, 1'b0, 16'h000B, 1'b0}, // R2
    {1'b0, 16'hFFFF, 1'b0, 16'h0001, 1'b0, 1'b0, 2'b01, 1'b0, 16'h0000, 1'b1}  // R4
  };

  function automatic string tag_of(input int i);
    case (i)
      0, 15:       return "R2";
      1, 3, 4:     return "R1";
      2, 5:        return "R3";
      6, 7, 16:    return "R4";
      8, 12:       return "R5";
      9, 10, 11:   return "R6";
      default:     return "R7";
    endcase
  endfunction

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic drive(input logic [55:0] v);
    acc_sign = v[55]; acc_mag = v[54:39];
    opd_sign = v[38]; opd_mag = v[37:22];
    neg_mod  = v[21]; abs_mod = v[20]; op_sel = v[19:18];
  endtask

  task automatic check_result(input string rq, input logic [55:0] v);
    chk(rq, "res_sign", 32'(res_sign), 32'(v[17]));
    chk(rq, "res_mag", 32'(res_mag), 32'(v[16:1]));
    chk(rq, "ovf_flag", 32'(ovf_flag), 32'(v[0]));
    chk("R8", "zero_flag", 32'(zero_flag), 32'(v[16:1] == 16'h0));
    chk("R8", "sign_flag", 32'(sign_flag), 32'(v[17]));
    chk("R9", "out_valid", 32'(out_valid), 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10", "out_valid", 32'(out_valid), 32'd0);
    chk("R10", "res_mag", 32'(res_mag), 32'd0);
    chk("R10", "flags", {29'd0, zero_flag, sign_flag, ovf_flag}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check_result(tag_of(i), VEC[i]);
    end

    // R9: idle cycle holds outputs (last result: 0, 0000, ovf 1)
    drive({1'b1, 16'h7777, 1'b1, 16'h1111, 1'b0, 1'b0, 2'b00, 17'd0, 1'b0});
    @(negedge clk);
    chk("R9", "idle out_valid", 32'(out_valid), 32'd0);
    chk("R9", "idle res_mag", 32'(res_mag), 32'd0);
    chk("R9", "idle ovf_flag", 32'(ovf_flag), 32'd1);
    chk("R9", "idle res_sign", 32'(res_sign), 32'd0);

    // R9: back-to-back requests, one result per cycle
    drive(VEC[2]); in_valid = 1'b1;
    @(negedge clk);
    check_result("R3", VEC[2]);
    drive(VEC[8]);
    @(negedge clk);
    in_valid = 1'b0;
    check_result("R5", VEC[8]);

    // R7: load ignores accumulator, different accumulator same operand
    drive({1'b0, 16'h0001, 1'b0, 16'h0042, 1'b0, 1'b1, 2'b10, 17'd0, 1'b0});
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R7", "load res_mag", 32'(res_mag), 32'h42);
    chk("R7", "load res_sign", 32'(res_sign), 32'd0);

    // R10: reset mid-run clears outputs
    rst_n = 1'b0;
    @(negedge clk);
    chk("R10", "reset res_mag", 32'(res_mag), 32'd0);
    chk("R10", "reset out_valid", 32'(out_valid), 32'd0);
    rst_n = 1'b1;

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule